// File: doc/BRIEF.md
# Link-Fed Stereo Serial Audio Output

This block turns stereo sample words carried on a 256-bit-per-frame audio link into a standard I2S stream at a fixed 48 kHz frame rate. It runs directly on the link bit clock, which ticks 256 times per audio frame. That same clock can also act as the master clock of an external DAC. A free-running 256-cycle frame counter produces the word-select clock. An optional divide-by-four output gives a 64fs serial bit clock.

Link slots arrive one at a time as a strobe with an index, a 20-bit word and a valid tag. A two-bit pair-select code decides which two link slots feed the left and right channels. The captured pair waits in a pending stage until the next frame boundary. It is then moved into the output stage and is sent during the frame that follows. If the slots are missing or tagged invalid, that frame carries silence.

Top module: `i2s_link_serializer`

## Requirements
- R1: The frame is 256 bit-clock cycles, with phase 0 in the first cycle after reset release. `i2s_lrclk` is low during phases 0..127 (left channel) and high during phases 128..255 (right channel) while `i2s_en` is 1.
- R2: While `bclk64_en` is 1, `i2s_bclk64` is high in the phases where phase mod 4 is 2 or 3, and low in the others. While `bclk64_en` is 0, it stays low.
- R3: Each channel half has 32 positions, where position = (phase mod 128) / 4. Position 0 carries 0. Positions 1..20 carry sample bits 19 down to 0, most significant bit first. Positions 21..31 carry 0.
- R4: The pair-select code maps to left/right link slots as follows: 0 → 3/4, 1 → 7/8, 2 → 6/9, 3 → 10/11. The code is applied when each slot strobe arrives. Strobes carrying any other index have no effect on the output.
- R5: The output words change only at the frame boundary (the edge from phase 255 to phase 0). A pair captured during a frame is sent in the next frame. Slots arriving mid-frame do not alter the words being sent.
- R6: A selected slot strobed with `slot_tag` = 0 makes its channel send an all-zero word in the next frame.
- R7: A captured pair is sent in one frame only. If no selected slot arrives during a frame, the next frame sends zero words.
- R8: While `i2s_en` is 0, `i2s_sd`, `i2s_lrclk`, `sd_oe` and `lr_oe` are low. While `i2s_en` is 1, `sd_oe` and `lr_oe` are high.
- R9: While `rst_n` is low, `i2s_sd`, `i2s_lrclk` and `i2s_bclk64` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_256fs | input | 1 | Link bit clock, 256 cycles per audio frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_en | input | 1 | Serial output enable |
| bclk64_en | input | 1 | Enable for the divided 64fs clock output |
| pair_sel | input | 2 | Slot pair selection code |
| slot_stb | input | 1 | A link slot word is present this cycle |
| slot_idx | input | 4 | Link slot number of the presented word |
| slot_data | input | 20 | Slot word, MSB-justified sample |
| slot_tag | input | 1 | Valid tag of the presented slot |
| i2s_sd | output | 1 | Serial data |
| i2s_lrclk | output | 1 | Word-select clock, high for the right channel |
| i2s_bclk64 | output | 1 | 64fs serial bit clock |
| sd_oe | output | 1 | Output enable for the data pin |
| lr_oe | output | 1 | Output enable for the word-select pin |

## Verification
A frame counter that slips shows up at once as a word-select edge at the wrong phase. Since every data bit is placed by that counter, every bit after the slip also lands in the wrong position. An error in the pending or output stage appears one frame later. It can show as the wrong sample pair, a word repeated in a frame that should be silent, or a word that changes part way through a frame. Bit-order or padding faults are visible within the first 32 positions of a channel.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

  localparam int LINK_IDX_W = 4;

  typedef struct packed {
    logic [LINK_IDX_W-1:0] left;
    logic [LINK_IDX_W-1:0] right;
  } slot_pair_t;

  // pair-select code to link slot numbers
  function automatic slot_pair_t slot_pair_of(input logic [1:0] code);
    slot_pair_t p;
    unique case (code)
      2'd0:    begin p.left = 4'd3;  p.right = 4'd4;  end
      2'd1:    begin p.left = 4'd7;  p.right = 4'd8;  end
      2'd2:    begin p.left = 4'd6;  p.right = 4'd9;  end
      default: begin p.left = 4'd10; p.right = 4'd11; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/i2s_frame_timer.sv
module i2s_frame_timer #(
  parameter int FRAME_LOG2 = 8,
  parameter int DIV_LOG2   = 2,
  localparam int POS_W     = FRAME_LOG2 - 1 - DIV_LOG2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [FRAME_LOG2-1:0] phase,
  output logic                  frame_end,
  output logic                  right_half,
  output logic                  bclk_div,
  output logic [POS_W-1:0]      bit_pos
);

  logic [FRAME_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign phase      = cnt_q;
  assign frame_end  = &cnt_q;
  assign right_half = cnt_q[FRAME_LOG2-1];
  assign bclk_div   = cnt_q[DIV_LOG2-1];
  assign bit_pos    = cnt_q[FRAME_LOG2-2:DIV_LOG2];

endmodule

// File: rtl/i2s_slot_capture.sv
module i2s_slot_capture
  import i2s_ser_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            pair_sel,
  input  logic                  slot_stb,
  input  logic [LINK_IDX_W-1:0] slot_idx,
  input  logic [SAMPLE_W-1:0]   slot_data,
  input  logic                  slot_tag,
  input  logic                  frame_end,
  output logic [SAMPLE_W-1:0]   word_l,
  output logic [SAMPLE_W-1:0]   word_r
);

  slot_pair_t            pair;
  logic                  hit_l, hit_r;
  logic [SAMPLE_W-1:0]   pend_l, pend_r;
  logic                  pv_l, pv_r;

  assign pair  = slot_pair_of(pair_sel);
  assign hit_l = slot_stb && (slot_idx == pair.left);
  assign hit_r = slot_stb && (slot_idx == pair.right);

  // pending stage: filled by slot strobes, emptied at each boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= '0; pend_r <= '0; pv_l <= 1'b0; pv_r <= 1'b0;
    end else begin
      if (hit_l) begin
        pend_l <= slot_data; pv_l <= slot_tag;
      end else if (frame_end) begin
        pv_l <= 1'b0;
      end
      if (hit_r) begin
        pend_r <= slot_data; pv_r <= slot_tag;
      end else if (frame_end) begin
        pv_r <= 1'b0;
      end
    end
  end

  // output stage: loaded only at the frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_l <= '0; word_r <= '0;
    end else if (frame_end) begin
      word_l <= pv_l ? pend_l : '0;
      word_r <= pv_r ? pend_r : '0;
    end
  end

endmodule

// File: rtl/i2s_bit_mux.sv
module i2s_bit_mux #(
  parameter int SAMPLE_W = 20,
  parameter int POS_W    = 5,
  localparam int CH_BITS = 1 << POS_W,
  localparam int PAD_W   = CH_BITS - 1 - SAMPLE_W
) (
  input  logic                en,
  input  logic                right_half,
  input  logic [POS_W-1:0]    bit_pos,
  input  logic [SAMPLE_W-1:0] word_l,
  input  logic [SAMPLE_W-1:0] word_r,
  output logic                sd
);

  // one channel slot, position 0 at the top: delay bit, sample, padding
  function automatic logic slot_bit(input logic [SAMPLE_W-1:0] w,
                                    input logic [POS_W-1:0]    p);
    logic [CH_BITS-1:0] lane;
    lane = {1'b0, w, {PAD_W{1'b0}}};
    return lane[~p];
  endfunction

  logic [SAMPLE_W-1:0] cur;
  assign cur = right_half ? word_r : word_l;
  assign sd  = en & slot_bit(cur, bit_pos);

endmodule

// File: rtl/i2s_link_serializer.sv
module i2s_link_serializer
  import i2s_ser_pkg::*;
#(
  parameter int SAMPLE_W   = 20,
  parameter int FRAME_LOG2 = 8,
  parameter int DIV_LOG2   = 2,
  localparam int POS_W     = FRAME_LOG2 - 1 - DIV_LOG2
) (
  input  logic                  clk_256fs,
  input  logic                  rst_n,
  input  logic                  i2s_en,
  input  logic                  bclk64_en,
  input  logic [1:0]            pair_sel,
  input  logic                  slot_stb,
  input  logic [LINK_IDX_W-1:0] slot_idx,
  input  logic [SAMPLE_W-1:0]   slot_data,
  input  logic                  slot_tag,
  output logic                  i2s_sd,
  output logic                  i2s_lrclk,
  output logic                  i2s_bclk64,
  output logic                  sd_oe,
  output logic                  lr_oe
);

  logic [FRAME_LOG2-1:0] phase_w;
  logic                  frame_end_w;
  logic                  right_w;
  logic                  bclk_w;
  logic [POS_W-1:0]      bit_pos_w;
  logic [SAMPLE_W-1:0]   lat_l_w, lat_r_w;

  i2s_frame_timer #(.FRAME_LOG2(FRAME_LOG2), .DIV_LOG2(DIV_LOG2)) u_timer (
    .clk(clk_256fs), .rst_n(rst_n), .phase(phase_w), .frame_end(frame_end_w),
    .right_half(right_w), .bclk_div(bclk_w), .bit_pos(bit_pos_w)
  );

  i2s_slot_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk(clk_256fs), .rst_n(rst_n), .pair_sel(pair_sel), .slot_stb(slot_stb),
    .slot_idx(slot_idx), .slot_data(slot_data), .slot_tag(slot_tag),
    .frame_end(frame_end_w), .word_l(lat_l_w), .word_r(lat_r_w)
  );

  i2s_bit_mux #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_mux (
    .en(i2s_en), .right_half(right_w), .bit_pos(bit_pos_w),
    .word_l(lat_l_w), .word_r(lat_r_w), .sd(i2s_sd)
  );

  assign i2s_lrclk  = i2s_en & right_w;
  assign i2s_bclk64 = bclk64_en & bclk_w;
  assign sd_oe      = i2s_en;
  assign lr_oe      = i2s_en;

endmodule

// File: rtl/i2s_link_serializer_chk.sv
module i2s_link_serializer_chk #(
  parameter int SAMPLE_W   = 20,
  parameter int FRAME_LOG2 = 8,
  parameter int POS_W      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic                  en64,
  input logic                  sd,
  input logic                  lr,
  input logic                  bclk,
  input logic                  oe,
  input logic [FRAME_LOG2-1:0] phase,
  input logic                  frame_end,
  input logic [POS_W-1:0]      bit_pos,
  input logic [SAMPLE_W-1:0]   lat_l,
  input logic [SAMPLE_W-1:0]   lat_r
);

  localparam logic [FRAME_LOG2-1:0] HALF = 1 << (FRAME_LOG2 - 1);

  AST_LR_RISE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $rose(lr)) |-> (phase == HALF)); // R1
  AST_BCLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en64 |-> !bclk); // R2
  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (bit_pos == '0 || int'(bit_pos) > SAMPLE_W)) |-> !sd); // R3
  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(lat_l) && $stable(lat_r))); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sd && !lr && !oe)); // R8

endmodule

bind i2s_link_serializer i2s_link_serializer_chk #(
  .SAMPLE_W(SAMPLE_W), .FRAME_LOG2(FRAME_LOG2), .POS_W(POS_W)
) u_chk (
  .clk(clk_256fs), .rst_n(rst_n), .en(i2s_en), .en64(bclk64_en), .sd(i2s_sd),
  .lr(i2s_lrclk), .bclk(i2s_bclk64), .oe(sd_oe), .phase(phase_w),
  .frame_end(frame_end_w), .bit_pos(bit_pos_w), .lat_l(lat_l_w), .lat_r(lat_r_w)
);

// File: tb/sim_i2s_link_serializer.sv
`timescale 1ns/1ps
module sim_i2s_link_serializer;

  logic clk = 1'b0;
  logic rst_n, i2s_en, bclk64_en, slot_stb, slot_tag;
  logic [1:0] pair_sel;
  logic [3:0] slot_idx;
  logic [19:0] slot_data;
  logic i2s_sd, i2s_lrclk, i2s_bclk64, sd_oe, lr_oe;

  int errors = 0;
  int checks = 0;
  int tick = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tick <= 0;
    else        tick <= tick + 1;
  end

  i2s_link_serializer u0 (
    .clk_256fs(clk), .rst_n(rst_n), .i2s_en(i2s_en), .bclk64_en(bclk64_en),
    .pair_sel(pair_sel), .slot_stb(slot_stb), .slot_idx(slot_idx),
    .slot_data(slot_data), .slot_tag(slot_tag), .i2s_sd(i2s_sd),
    .i2s_lrclk(i2s_lrclk), .i2s_bclk64(i2s_bclk64), .sd_oe(sd_oe), .lr_oe(lr_oe)
  );

  // vector: {sel[1:0], left tag, right tag, seed[11:0]}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 1'b1, 1'b1, 12'h0A1},
    {2'd1, 1'b1, 1'b1, 12'hF3C},
    {2'd2, 1'b1, 1'b1, 12'h5E7},
    {2'd3, 1'b1, 1'b1, 12'hFFF},
    {2'd2, 1'b1, 1'b0, 12'h7B2},  // R6 right untagged
    {2'd1, 1'b0, 1'b1, 12'h314}   // R6 left untagged
  };

  function automatic logic [19:0] sv(input int seed, input int i);
    return 20'((seed * 977 + i * 40961) ^ (i << 15) ^ (seed << 8));
  endfunction

  function automatic int left_of(input int sel);
    case (sel) 0: return 3; 1: return 7; 2: return 6; default: return 10; endcase
  endfunction
  function automatic int right_of(input int sel);
    case (sel) 0: return 4; 1: return 8; 2: return 9; default: return 11; endcase
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_phase(input int p);
    @(negedge clk);
    while ((tick % 256) != p) @(negedge clk);
  endtask

  // strobe slots 1..12; tags for the given left/right index, others valid
  task automatic send_all(input int seed, input int li, input int ri,
                          input bit tl, input bit tr, input bit only_odd);
    for (int i = 1; i <= 12; i++) begin
      if (only_odd && (i == li || i == ri)) continue;
      slot_stb  = 1'b1;
      slot_idx  = 4'(i);
      slot_data = sv(seed, i);
      slot_tag  = (i == li) ? tl : (i == ri) ? tr : 1'b1;
      @(negedge clk);
    end
    slot_stb = 1'b0;
  endtask

  // call at a negedge with phase 0; returns at phase 0 of the next frame
  task automatic observe(input logic [19:0] el, input logic [19:0] er,
                         input bit want_bclk, input string rq);
    logic [19:0] gl, gr;
    int padbad, lrbad, bkbad, ph, pos;
    bit rt;
    gl = '0; gr = '0; padbad = 0; lrbad = 0; bkbad = 0;
    for (int k = 0; k < 256; k++) begin
      ph  = tick % 256;
      pos = (ph % 128) / 4;
      rt  = (ph >= 128);
      if (i2s_lrclk !== rt) lrbad++;
      if (i2s_bclk64 !== (want_bclk ? ((ph % 4) >= 2) : 1'b0)) bkbad++;
      if (pos >= 1 && pos <= 20) begin
        if (rt) gr[20-pos] = i2s_sd; else gl[20-pos] = i2s_sd;
      end else if (i2s_sd !== 1'b0) padbad++;
      @(negedge clk);
    end
    check(gl === el, {rq, " left word"}, int'(gl), int'(el));
    check(gr === er, {rq, " right word"}, int'(gr), int'(er));
    check(lrbad == 0, "R1 lrclk phases", lrbad, 0);
    check(bkbad == 0, "R2 bclk64 phases", bkbad, 0);
    check(padbad == 0, "R3 delay/pad bits zero", padbad, 0);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; i2s_en = 1'b1; bclk64_en = 1'b1; pair_sel = 2'd0;
    slot_stb = 1'b0; slot_idx = '0; slot_data = '0; slot_tag = 1'b0;
    repeat (5) @(negedge clk);
    // R9 reset state
    check(i2s_sd === 1'b0 && i2s_lrclk === 1'b0 && i2s_bclk64 === 1'b0,
          "R9 reset outputs", {i2s_sd, i2s_lrclk, i2s_bclk64}, 0);
    rst_n = 1'b1;

    // table walk: R3 R4 R6
    for (int v = 0; v < 6; v++) begin
      int sel, seed, li, ri;
      bit tl, tr;
      sel = int'(VEC[v][15:14]); tl = VEC[v][13]; tr = VEC[v][12];
      seed = int'(VEC[v][11:0]); li = left_of(sel); ri = right_of(sel);
      wait_phase(128);
      pair_sel = 2'(sel);
      send_all(seed, li, ri, tl, tr, 1'b0);
      wait_phase(0);
      observe(tl ? sv(seed, li) : 20'h0, tr ? sv(seed, ri) : 20'h0, 1'b1, "R4 slot map");
    end

    // R7: the frame after the last one, with no slots sent, is silent
    observe(20'h0, 20'h0, 1'b1, "R7 no new pair");

    // R4: only non-selected indices strobed -> silence
    wait_phase(128);
    pair_sel = 2'd0;
    send_all(77, 3, 4, 1'b1, 1'b1, 1'b1);
    wait_phase(0);
    observe(20'h0, 20'h0, 1'b1, "R4 other slots ignored");

    // R5: pair A sent, then pair B arrives mid-frame during A's frame
    wait_phase(128);
    send_all(300, 3, 4, 1'b1, 1'b1, 1'b0);
    wait_phase(0);
    fork
      observe(sv(300, 3), sv(300, 4), 1'b1, "R5 mid-frame hold");
      begin
        repeat (64) @(negedge clk);
        send_all(301, 3, 4, 1'b1, 1'b1, 1'b0);
      end
    join
    observe(sv(301, 3), sv(301, 4), 1'b1, "R5 next-frame load");

    // R2: divided clock disabled
    wait_phase(128);
    bclk64_en = 1'b0;
    send_all(400, 3, 4, 1'b1, 1'b1, 1'b0);
    wait_phase(0);
    observe(sv(400, 3), sv(400, 4), 1'b0, "R2 gated clock data");
    bclk64_en = 1'b1;

    // R8: serial output disabled for one frame
    begin
      int bad;
      bad = 0;
      wait_phase(128);
      send_all(500, 3, 4, 1'b1, 1'b1, 1'b0);
      wait_phase(0);
      i2s_en = 1'b0;
      for (int k = 0; k < 256; k++) begin
        #1;
        if (i2s_sd !== 1'b0 || i2s_lrclk !== 1'b0 || sd_oe !== 1'b0 || lr_oe !== 1'b0) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R8 disabled outputs low", bad, 0);
      i2s_en = 1'b1;
      #1;
      check(sd_oe === 1'b1 && lr_oe === 1'b1, "R8 output enables high",
            {sd_oe, lr_oe}, 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule